// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block places a small microcontroller into one of two low-power modes and brings it back out. Software writes a configuration word over a simple register bus. The word holds a suspend request, a sleep request and one wake enable for each of six event sources. In suspend, the system clock enable and every internal oscillator enable go low. Sleep drops the core regulator enable as well. While the device sleeps, the digital output pins keep the values they had on entry.

The block runs on an always-on reference clock. Each asynchronous event input passes through a synchronizer before edge detection. A detected edge sets a sticky wake flag, and software clears a flag by writing 1 to its position. A wake returns the block to run mode. When the exit is from sleep, the block pulls an active-low wake-request line to signal external devices. A falling edge on the reset pin also ends suspend, even when it is too short to reset the device, and it sets a flag of its own.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After reset, clk_en_o, every bit of osc_en_o, vreg_en_o and wake_req_n_o are 1, gpio_out_o follows gpio_in_i, and both registers read 0.
- R2: Register 0 holds the wake enables in bits 5:0, read back as written. Its bit 6 reads 1 only while in suspend and its bit 7 reads 1 only while in sleep. Both read 0 in run mode, so the mode bits clear themselves on wake.
- R3: Writing register 0 with bit 6 set and bit 7 clear enters suspend on that clock edge. clk_en_o and all of osc_en_o drop to 0, and vreg_en_o stays 1.
- R4: Writing register 0 with bit 7 set enters sleep, whatever bit 6 holds. clk_en_o, osc_en_o and vreg_en_o all drop to 0.
- R5: The sources map to wake_src_i bits as follows: 0 comparator rising edge, 1 port match, 2 clock alarm, 3 clock oscillator failure, 4 supply monitor, 5 pulse-count reached. A rising edge on a source sets the matching flag bit of register 1 whether or not the source is enabled. Flags are sticky and are cleared by writing 1 to their bit of register 1.
- R6: Only an enabled source can end a low-power mode. An input that rises just before clock edge k is seen two edges later: the flag sets and run mode returns on edge k+2.
- R7: A falling edge on rst_pin_n_i sets flag bit 6 of register 1 and ends suspend, with no enable needed. It does not end sleep.
- R8: For the first two clocks after a suspend exit, register 1 reads 0. After that it shows the captured flags. A sleep exit has no such blanking.
- R9: After a sleep exit, wake_req_n_o is 0 for exactly 8 clocks and then returns to 1.
- R10: While in sleep, gpio_out_o holds the gpio_in_i value present on the entry edge. In the other modes it follows gpio_in_i.
- R11: A mode request is refused, and the block stays in run mode, when an enabled source already has its flag set or its edge is arriving on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 configuration, 1 wake flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| wake_src_i | input | 6 | Asynchronous wake event inputs |
| rst_pin_n_i | input | 1 | Asynchronous reset pin level |
| gpio_in_i | input | 8 | Output-pin values from the port logic |
| clk_en_o | output | 1 | System clock enable |
| osc_en_o | output | 3 | Internal oscillator enables |
| vreg_en_o | output | 1 | Core regulator enable |
| wake_req_n_o | output | 1 | Active-low wake request to external devices |
| gpio_out_o | output | 8 | Output-pin values, held during sleep |

## Verification
The bench sends edges from disabled sources during both modes. A design that ignored the enable mask would wake on these edges, and one that gated flag capture by the enable would lose the flag. It reads the flags in the two clocks right after a suspend exit and again in the third clock, so a blanking window that is off by one shows up. It also counts the length of the wake-request pulse. It tries to enter a low-power mode while an enabled flag is pending, which catches a controller that would sleep through a pending wake. It glitches the reset pin in sleep and then in suspend, which separates the two exit rules. It changes the pin inputs during sleep to check that the outputs are held.

// File: rtl/lpm_pkg.sv
// Shared constants and types for the low-power mode wake controller.
// Assumes an 8-bit register bus and six event sources.
package lpm_pkg;
    localparam int NUM_SRC     = 6;
    localparam int DATA_W      = 8;
    localparam int BIT_SUSPEND = 6;
    localparam int BIT_SLEEP   = 7;
    localparam int FLAG_W      = NUM_SRC + 1;   // sources plus reset-pin flag

    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_SUSPEND = 2'd1,
        PM_SLEEP   = 2'd2
    } pm_state_t;
endpackage

// File: rtl/lpm_sync_edge.sv
// Multi-stage synchronizer followed by rise/fall edge detection.
// Assumes inputs are asynchronous levels; IDLE sets the reset value of
// every stage so that no false edge is seen after reset.
module lpm_sync_edge #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [STAGES-1:0][W-1:0] chain_q;
    logic [W-1:0]             prev_q;
    logic [W-1:0]             sync_w;

    assign sync_w = chain_q[STAGES-1];

    // Shift the async level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{IDLE}};
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= sync_w;
    end

    assign rise_o = sync_w & ~prev_q;
    assign fall_o = ~sync_w & prev_q;
endmodule

// File: rtl/lpm_wake_flags.sv
// Sticky wake flags with write-1-to-clear and post-suspend read blanking.
// Bit NSRC is the reset-pin flag. Assumes set wins over clear on the same edge.
module lpm_wake_flags #(
    parameter int NSRC         = 6,
    parameter int BLANK_CYCLES = 2,
    localparam int FW          = NSRC + 1,
    localparam int BW          = $clog2(BLANK_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NSRC-1:0] src_rise_i,
    input  logic          pin_fall_i,
    input  logic          clr_we_i,
    input  logic [FW-1:0] clr_mask_i,
    input  logic          blank_start_i,
    output logic [FW-1:0] flags_o,
    output logic [FW-1:0] flags_rd_o
);
    logic [FW-1:0] set_w;
    logic [FW-1:0] flag_q;
    logic [BW-1:0] blank_q;

    assign set_w = {pin_fall_i, src_rise_i};

    generate
        for (genvar i = 0; i < FW; i++) begin : g_flag
            // Capture an event into its sticky flag, clear on write-1.
            always_ff @(posedge clk) begin
                if (!rst_n) flag_q[i] <= 1'b0;
                else        flag_q[i] <= set_w[i] | (flag_q[i] & ~(clr_we_i & clr_mask_i[i]));
            end

            // R5: a flag stays set unless a clear write was made.
            a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[i] && !clr_we_i) |=> flag_q[i]);
        end
    endgenerate

    // Count down the read-blanking window after a suspend exit.
    always_ff @(posedge clk) begin
        if (!rst_n)             blank_q <= '0;
        else if (blank_start_i) blank_q <= BW'(BLANK_CYCLES);
        else if (blank_q != '0) blank_q <= blank_q - 1'b1;
    end

    assign flags_o    = flag_q;
    assign flags_rd_o = (blank_q != '0) ? '0 : flag_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
// Run/suspend/sleep state machine: rail enables, wake-request pulse and
// output-pin hold. Assumes pending_i already includes same-edge events.
module lpm_mode_fsm
    import lpm_pkg::*;
#(
    parameter int NSRC       = 6,
    parameter int NUM_OSC    = 3,
    parameter int GPIO_W     = 8,
    parameter int REQ_CYCLES = 8,
    localparam int RW        = $clog2(REQ_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic              req_sleep_i,
    input  logic              req_suspend_i,
    input  logic [NSRC-1:0]   wake_en_i,
    input  logic [NSRC-1:0]   src_rise_i,
    input  logic              pin_fall_i,
    input  logic              pending_i,
    input  logic [GPIO_W-1:0] gpio_in_i,
    output pm_state_t         state_o,
    output logic              susp_exit_o,
    output logic              clk_en_o,
    output logic [NUM_OSC-1:0] osc_en_o,
    output logic              vreg_en_o,
    output logic              wake_req_n_o,
    output logic [GPIO_W-1:0] gpio_out_o
);
    pm_state_t         state_q, state_d;
    logic              wake_hit;
    logic [RW-1:0]     req_q;
    logic [GPIO_W-1:0] hold_q;

    assign wake_hit = |(src_rise_i & wake_en_i);

    // Choose the next mode from requests and wake events.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (cfg_we_i && !pending_i) begin
                    if (req_sleep_i)        state_d = PM_SLEEP;
                    else if (req_suspend_i) state_d = PM_SUSPEND;
                end
            end
            PM_SUSPEND: if (wake_hit || pin_fall_i) state_d = PM_RUN;
            PM_SLEEP:   if (wake_hit)               state_d = PM_RUN;
            default:    state_d = PM_RUN;
        endcase
    end

    // Register the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_d;
    end

    // Time the wake-request pulse after a sleep exit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      req_q <= '0;
        else if (state_q == PM_SLEEP && state_d == PM_RUN) req_q <= RW'(REQ_CYCLES);
        else if (req_q != '0)                            req_q <= req_q - 1'b1;
    end

    // Latch the output-pin values on the sleep entry edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      hold_q <= '0;
        else if (state_q == PM_RUN && state_d == PM_SLEEP) hold_q <= gpio_in_i;
    end

    assign state_o      = state_q;
    assign susp_exit_o  = (state_q == PM_SUSPEND) && (state_d == PM_RUN);
    assign clk_en_o     = (state_q == PM_RUN);
    assign osc_en_o     = {NUM_OSC{state_q == PM_RUN}};
    assign vreg_en_o    = (state_q != PM_SLEEP);
    assign wake_req_n_o = (req_q == '0);
    assign gpio_out_o   = (state_q == PM_SLEEP) ? hold_q : gpio_in_i;

    // R11: a pending enabled wake keeps the block in run mode.
    a_r11_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && pending_i) |=> (state_q == PM_RUN));
    // R6: without a qualifying event a low-power mode is kept.
    a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PM_RUN && !wake_hit && !pin_fall_i) |=> (state_q != PM_RUN));
    // R7: the reset pin alone never ends sleep.
    a_r7_pin_no_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_SLEEP && !wake_hit) |=> (state_q == PM_SLEEP));
    // R9: a sleep exit asserts the wake request at once.
    a_r9_req_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_SLEEP && state_d == PM_RUN) |=> !wake_req_n_o);
    // R10: the output pins do not move during sleep.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_SLEEP && state_d == PM_SLEEP) |=> $stable(gpio_out_o));
endmodule

// File: rtl/lpm_wake_ctrl.sv
// Top of the low-power mode wake controller: register bus decode,
// enable register, and wiring of synchronizers, flags and mode FSM.
// Assumes clk never stops; clk_en_o gates the system clock elsewhere.
module lpm_wake_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_OSC      = 3,
    parameter int GPIO_W       = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int BLANK_CYCLES = 2,
    parameter int REQ_CYCLES   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic               reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] wake_src_i,
    input  logic               rst_pin_n_i,
    input  logic [GPIO_W-1:0]  gpio_in_i,
    output logic               clk_en_o,
    output logic [NUM_OSC-1:0] osc_en_o,
    output logic               vreg_en_o,
    output logic               wake_req_n_o,
    output logic [GPIO_W-1:0]  gpio_out_o
);
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] src_rise;
    logic [NUM_SRC-1:0] src_fall_unused;
    logic               pin_rise_unused;
    logic               pin_fall;
    logic [FLAG_W-1:0]  flags_raw;
    logic [FLAG_W-1:0]  flags_rd;
    logic               cfg_we, clr_we, pending, susp_exit;
    pm_state_t          state;

    assign cfg_we  = reg_we && (reg_addr == 1'b0);
    assign clr_we  = reg_we && (reg_addr == 1'b1);
    assign pending = |((flags_raw[NUM_SRC-1:0] | src_rise) & en_q);

    // Hold the per-source wake enables.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (cfg_we) en_q <= reg_wdata[NUM_SRC-1:0];
    end

    lpm_sync_edge #(.W(NUM_SRC), .STAGES(SYNC_STAGES), .IDLE('0)) i_src_sync (
        .clk(clk), .rst_n(rst_n), .async_i(wake_src_i),
        .rise_o(src_rise), .fall_o(src_fall_unused)
    );

    lpm_sync_edge #(.W(1), .STAGES(SYNC_STAGES), .IDLE(1'b1)) i_pin_sync (
        .clk(clk), .rst_n(rst_n), .async_i(rst_pin_n_i),
        .rise_o(pin_rise_unused), .fall_o(pin_fall)
    );

    lpm_wake_flags #(.NSRC(NUM_SRC), .BLANK_CYCLES(BLANK_CYCLES)) i_flags (
        .clk(clk), .rst_n(rst_n), .src_rise_i(src_rise), .pin_fall_i(pin_fall),
        .clr_we_i(clr_we), .clr_mask_i(reg_wdata[FLAG_W-1:0]),
        .blank_start_i(susp_exit), .flags_o(flags_raw), .flags_rd_o(flags_rd)
    );

    lpm_mode_fsm #(.NSRC(NUM_SRC), .NUM_OSC(NUM_OSC), .GPIO_W(GPIO_W),
                   .REQ_CYCLES(REQ_CYCLES)) i_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we),
        .req_sleep_i(reg_wdata[BIT_SLEEP]), .req_suspend_i(reg_wdata[BIT_SUSPEND]),
        .wake_en_i(en_q), .src_rise_i(src_rise), .pin_fall_i(pin_fall),
        .pending_i(pending), .gpio_in_i(gpio_in_i), .state_o(state),
        .susp_exit_o(susp_exit), .clk_en_o(clk_en_o), .osc_en_o(osc_en_o),
        .vreg_en_o(vreg_en_o), .wake_req_n_o(wake_req_n_o), .gpio_out_o(gpio_out_o)
    );

    // Drive read data for the selected register.
    always_comb begin
        if (reg_addr == 1'b0)
            reg_rdata = {state == PM_SLEEP, state == PM_SUSPEND, en_q};
        else
            reg_rdata = {{(DATA_W-FLAG_W){1'b0}}, flags_rd};
    end

    // R8: flags read as zero on the clock after a suspend exit.
    a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
        susp_exit |=> (flags_rd == '0));
    // R3: entering suspend keeps the regulator on.
    a_r3_suspend_vreg: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_RUN && !pending && cfg_we && reg_wdata[BIT_SUSPEND] && !reg_wdata[BIT_SLEEP])
        |=> (vreg_en_o && !clk_en_o));
endmodule

// File: tb/test_lpm_wake_ctrl.sv
// Self-checking bench for lpm_wake_ctrl: directed corners plus seeded random.
module test_lpm_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] wake_src_i = '0;
    logic       rst_pin_n_i = 1'b1;
    logic [7:0] gpio_in_i = '0;
    logic       clk_en_o, vreg_en_o, wake_req_n_o;
    logic [2:0] osc_en_o;
    logic [7:0] gpio_out_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    lpm_wake_ctrl i_lpm_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_src_i(wake_src_i),
        .rst_pin_n_i(rst_pin_n_i), .gpio_in_i(gpio_in_i), .clk_en_o(clk_en_o),
        .osc_en_o(osc_en_o), .vreg_en_o(vreg_en_o), .wake_req_n_o(wake_req_n_o),
        .gpio_out_o(gpio_out_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected wake from a source edge given the enable mask.
    function automatic bit exp_wake(input logic [5:0] en, input int src);
        return en[src];
    endfunction

    // Expected rails as {clk_en, osc(3), vreg} for a mode 0 run,1 suspend,2 sleep.
    function automatic logic [4:0] exp_rails(input int mode);
        case (mode)
            0: return 5'b1_111_1;
            1: return 5'b0_000_1;
            default: return 5'b0_000_0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_0042));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        chk("R1 rails", {clk_en_o, osc_en_o, vreg_en_o}, exp_rails(0));
        chk("R1 wake_req", wake_req_n_o, 1);
        rd(0, d); chk("R1 cfg", d, 0);
        rd(1, d); chk("R1 flags", d, 0);

        // R2: enables read back, mode bits zero in run
        wr(0, 8'h03);
        rd(0, d); chk("R2 cfg readback", d, 8'h03);

        // R3: suspend
        wr(0, 8'h43);
        chk("R3 suspend rails", {clk_en_o, osc_en_o, vreg_en_o}, exp_rails(1));
        rd(0, d); chk("R2 suspend bit", d, 8'h43);

        // R6/R5: disabled source (pulse counter, bit5) sets flag but no wake
        @(negedge clk); wake_src_i[5] = 1'b1;
        cyc(4);
        chk("R6 disabled no wake", clk_en_o, 0);
        rd(1, d); chk("R5 disabled flag captured", d, 8'h20);
        wake_src_i[5] = 1'b0;

        // R6/R8: enabled comparator edge wakes on edge k+2, blank two clocks
        @(negedge clk); wake_src_i[0] = 1'b1;
        cyc(2);
        chk("R6 latency not yet", clk_en_o, 0);
        cyc(1);
        chk("R6 wake rails", {clk_en_o, osc_en_o, vreg_en_o}, exp_rails(0));
        rd(1, d); chk("R8 blank clock 1", d, 0);
        cyc(1);
        rd(1, d); chk("R8 blank clock 2", d, 0);
        cyc(1);
        rd(1, d); chk("R8 flags visible", d, 8'h21);
        rd(0, d); chk("R2 mode bits cleared", d, 8'h03);
        chk("R9 no request after suspend", wake_req_n_o, 1);

        // R11: refused while enabled flag pending
        wr(0, 8'h43);
        chk("R11 refused", clk_en_o, 1);
        rd(0, d); chk("R11 mode bits", d, 8'h03);

        // R5: write-1-to-clear only bit0
        wr(1, 8'h01);
        rd(1, d); chk("R5 partial clear", d, 8'h20);
        wr(1, 8'h7F);
        wake_src_i[0] = 1'b0;
        cyc(3);

        // R4/R10: both mode bits -> sleep; pins held
        gpio_in_i = 8'hA5;
        wr(0, 8'hC3);
        chk("R4 sleep rails", {clk_en_o, osc_en_o, vreg_en_o}, exp_rails(2));
        rd(0, d); chk("R4 sleep priority", d, 8'h83);
        gpio_in_i = 8'h3C;
        cyc(1);
        chk("R10 hold", gpio_out_o, 8'hA5);

        // R7: reset-pin glitch does not end sleep
        rst_pin_n_i = 1'b0; cyc(1); rst_pin_n_i = 1'b1;
        cyc(4);
        chk("R7 sleep kept", vreg_en_o, 0);
        rd(1, d); chk("R7 pin flag", d, 8'h40);
        chk("R10 hold later", gpio_out_o, 8'hA5);

        // R9: port match wakes sleep; request low exactly 8 clocks
        wake_src_i[1] = 1'b1;
        cyc(3);
        chk("R6 sleep wake", vreg_en_o, 1);
        chk("R10 released", gpio_out_o, 8'h3C);
        rd(1, d); chk("R8 no blank after sleep", d, 8'h42);
        begin
            int lowcnt = 0;
            for (int i = 0; i < 8; i++) begin
                if (!wake_req_n_o) lowcnt++;
                cyc(1);
            end
            chk("R9 low cycles", lowcnt, 8);
            chk("R9 released", wake_req_n_o, 1);
        end
        wake_src_i[1] = 1'b0;
        wr(1, 8'h7F);
        cyc(3);

        // R7: reset-pin glitch ends suspend with no enable
        wr(0, 8'h40);
        chk("R3 suspend no enables", clk_en_o, 0);
        rst_pin_n_i = 1'b0; cyc(1); rst_pin_n_i = 1'b1;
        cyc(2);
        chk("R7 pin wake", clk_en_o, 1);
        cyc(2);
        rd(1, d); chk("R7 pin flag suspend", d, 8'h40);
        wr(1, 8'h7F);

        // Random phase: R5 R6 R3 R4
        for (int it = 0; it < 40; it++) begin
            logic [5:0] en;
            int j, w, mode;
            bit woke;
            logic [7:0] expf;
            en = 6'($urandom);
            w = int'($urandom % 6);
            j = int'($urandom % 6);
            mode = 1 + int'($urandom % 2);
            en[w] = 1'b1;
            wr(1, 8'h7F);
            wr(0, {mode == 2, mode == 1, en});
            chk("R3/R4 random entry", {clk_en_o, osc_en_o, vreg_en_o}, exp_rails(mode));
            wake_src_i[j] = 1'b1; cyc(3);
            woke = exp_wake(en, j);
            chk("R6 random wake", clk_en_o, woke);
            wake_src_i[j] = 1'b0; cyc(3);
            expf = 8'(1 << j);
            if (!woke) begin
                wake_src_i[w] = 1'b1; cyc(3);
                chk("R6 random enabled wake", clk_en_o, 1);
                wake_src_i[w] = 1'b0; cyc(3);
                expf = expf | 8'(1 << w);
            end
            cyc(10);
            rd(1, d); chk("R5 random flags", d, expf);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule